// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This block decides, for a single instruction opcode, whether a conditional control transfer is taken. It takes the 8-bit opcode together with the processor's 16-bit flag word and its 16-bit count register. It covers three groups of opcodes. The first is the sixteen flag-tested jumps. The second is the three count-driven loop forms. The third is the jump taken when the count register is zero. Every other opcode is reported as not a branch.

Loop forms decrement the count first and test the decremented value. That new count is always offered for write-back, whether or not the branch is taken. Every result passes through one register stage, so the answer for an input accepted on one clock edge is visible after that edge, one cycle of latency. The surrounding pipeline adds the displacement to the instruction pointer. It also fetches the target and commits the count write.

Top module: `branch_cond_eval`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid, taken, not_branch and count_wr are 0 and count_out is all zeros.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. The other outputs then carry the result for the opcode, flags and count that were presented with that in_valid.
- R3: For opcodes 0111cccc with c0 = 0, taken follows a base test on flag bits. OF is bit 11, SF is bit 7, ZF is bit 6, PF is bit 2 and CF is bit 0. The base test for each ccc field is: 000 tests OF=1, 001 tests CF=1, 010 tests ZF=1, 100 tests SF=1, and 101 tests PF=1.
- R4: For opcodes 0111cccc with c0 = 1, taken is the inverse of the base test of the even opcode with the same upper seven bits.
- R5: The comparison tests use these ccc fields. 011 is unsigned below-or-equal, CF=1 or ZF=1. 110 is signed less, SF differs from OF. 111 is signed less-or-equal, ZF=1 or SF differs from OF.
- R6: For opcode 11100010, count_out is the count minus one, wrapping modulo 2^16, and count_wr is 1. taken is 1 exactly when that new count is nonzero.
- R7: Opcode 11100001 behaves like R6 but also requires ZF=1 to take the branch. Opcode 11100000 behaves like R6 but also requires ZF=0. Both set count_wr to 1 and output the decremented count regardless of the outcome.
- R8: For opcode 11100011, taken is 1 exactly when the count is zero. count_out equals the input count and count_wr is 0.
- R9: Any opcode outside 0111xxxx and 111000xx gives not_branch = 1, taken = 0 and count_wr = 0, with count_out equal to the input count. Every recognised opcode gives not_branch = 0.
- R10: Flag bits other than 0, 2, 6, 7 and 11 have no effect on taken.
- R11: In a cycle after one with in_valid low, taken, not_branch, count_wr and count_out keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode, flags and count are valid this cycle |
| opcode | input | 8 | First byte of the instruction |
| flags | input | FLAG_W (16) | Processor flag word |
| count | input | CNT_W (16) | Current count register value |
| out_valid | output | 1 | Result registered from the previous cycle's input |
| taken | output | 1 | Branch is taken |
| not_branch | output | 1 | Opcode is not handled by this evaluator |
| count_wr | output | 1 | count_out should be written back to the count register |
| count_out | output | CNT_W (16) | Updated count for loop forms, unchanged count otherwise |

## Verification
The bench builds the block with its defaults, CNT_W = 16 and FLAG_W = 16, so the count wraps at a 16-bit boundary. With these values, a loop entered with a count of zero wraps to 16'hFFFF and is taken. A count of one decrements to zero and falls through. Both cases need only a single vector each. The full flag width lets the bench set every undefined and control flag bit high and low around the same jump, which exercises R10 directly.

// File: rtl/br_eval_pkg.sv
package br_eval_pkg;

  localparam int unsigned FB_CF = 0;
  localparam int unsigned FB_PF = 2;
  localparam int unsigned FB_ZF = 6;
  localparam int unsigned FB_SF = 7;
  localparam int unsigned FB_OF = 11;

  localparam int unsigned OPC_W = 8;
  localparam int unsigned CC_W  = 3;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_JCC    = 3'd1,
    K_LOOP   = 3'd2,
    K_LOOPZ  = 3'd3,
    K_LOOPNZ = 3'd4,
    K_JCXZ   = 3'd5
  } br_kind_e;

  // Base (non-inverted) flag test selected by the three condition bits
  function automatic logic flag_base(input logic [CC_W-1:0] cc,
                                     input logic of_f, input logic cf_f,
                                     input logic zf_f, input logic sf_f,
                                     input logic pf_f);
    logic lt;
    lt = sf_f ^ of_f;
    unique case (cc)
      3'd0: flag_base = of_f;
      3'd1: flag_base = cf_f;
      3'd2: flag_base = zf_f;
      3'd3: flag_base = cf_f | zf_f;
      3'd4: flag_base = sf_f;
      3'd5: flag_base = pf_f;
      3'd6: flag_base = lt;
      default: flag_base = zf_f | lt;
    endcase
  endfunction

  // Opcode class
  function automatic br_kind_e classify(input logic [OPC_W-1:0] opc);
    br_kind_e k;
    k = K_NONE;
    if (opc[7:4] == 4'b0111) begin
      k = K_JCC;
    end else if (opc[7:2] == 6'b111000) begin
      unique case (opc[1:0])
        2'b00: k = K_LOOPNZ;
        2'b01: k = K_LOOPZ;
        2'b10: k = K_LOOP;
        default: k = K_JCXZ;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/br_opc_decode.sv
module br_opc_decode
  import br_eval_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output br_kind_e         kind,
  output logic [CC_W-1:0]  cc,
  output logic             inv
);
  always_comb begin
    kind = classify(opc);
    cc   = opc[CC_W:1];
    inv  = opc[0];
  end
endmodule

// File: rtl/br_flag_cond.sv
module br_flag_cond
  import br_eval_pkg::*;
#(
  parameter int unsigned FLAG_W = 16
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [CC_W-1:0]   cc,
  input  logic              inv,
  output logic              hit
);
  localparam int unsigned TOP_BIT = FB_OF;

  logic of_f, cf_f, zf_f, sf_f, pf_f;

  generate
    if (FLAG_W > TOP_BIT) begin : g_wide
      assign of_f = flags[FB_OF];
      assign sf_f = flags[FB_SF];
      assign zf_f = flags[FB_ZF];
      assign pf_f = flags[FB_PF];
      assign cf_f = flags[FB_CF];
    end else begin : g_narrow
      assign of_f = 1'b0;
      assign sf_f = 1'b0;
      assign zf_f = 1'b0;
      assign pf_f = 1'b0;
      assign cf_f = 1'b0;
    end
  endgenerate

  always_comb begin
    hit = flag_base(cc, of_f, cf_f, zf_f, sf_f, pf_f) ^ inv;
  end
endmodule

// File: rtl/br_count_unit.sv
module br_count_unit
  import br_eval_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  br_kind_e         kind,
  input  logic [CNT_W-1:0] count,
  input  logic             zf,
  output logic [CNT_W-1:0] next_cnt,
  output logic             cnt_wr,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] dec;
  logic             dec_nz;
  logic             cx_zero;

  always_comb begin
    dec     = count - ONE;
    dec_nz  = |dec;
    cx_zero = ~|count;

    next_cnt = count;
    cnt_wr   = 1'b0;
    hit      = 1'b0;
    unique case (kind)
      K_LOOP:   begin next_cnt = dec; cnt_wr = 1'b1; hit = dec_nz;        end
      K_LOOPZ:  begin next_cnt = dec; cnt_wr = 1'b1; hit = dec_nz & zf;   end
      K_LOOPNZ: begin next_cnt = dec; cnt_wr = 1'b1; hit = dec_nz & ~zf;  end
      K_JCXZ:   hit = cx_zero;
      default:  ;
    endcase
  end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import br_eval_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [FLAG_W-1:0] flags,
  input  logic [CNT_W-1:0]  count,
  output logic              out_valid,
  output logic              taken,
  output logic              not_branch,
  output logic              count_wr,
  output logic [CNT_W-1:0]  count_out
);
  br_kind_e         kind;
  logic [CC_W-1:0]  cc;
  logic             inv;
  logic             flag_hit;
  logic             cnt_hit;
  logic             cnt_wr_c;
  logic [CNT_W-1:0] cnt_next;
  logic             take_c;

  // Named decode events for the checker
  logic evt_jcc, evt_loop_plain, evt_loop_z, evt_loop_nz, evt_cx_test, evt_not_branch;

  br_opc_decode u_dec (
    .opc  (opcode),
    .kind (kind),
    .cc   (cc),
    .inv  (inv)
  );

  br_flag_cond #(.FLAG_W(FLAG_W)) u_flag (
    .flags (flags),
    .cc    (cc),
    .inv   (inv),
    .hit   (flag_hit)
  );

  br_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .kind     (kind),
    .count    (count),
    .zf       (flags[FB_ZF]),
    .next_cnt (cnt_next),
    .cnt_wr   (cnt_wr_c),
    .hit      (cnt_hit)
  );

  always_comb begin
    evt_jcc        = (kind == K_JCC);
    evt_loop_plain = (kind == K_LOOP);
    evt_loop_z     = (kind == K_LOOPZ);
    evt_loop_nz    = (kind == K_LOOPNZ);
    evt_cx_test    = (kind == K_JCXZ);
    evt_not_branch = (kind == K_NONE);
    take_c         = evt_jcc ? flag_hit : cnt_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      not_branch <= 1'b0;
      count_wr   <= 1'b0;
      count_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken      <= take_c;
        not_branch <= evt_not_branch;
        count_wr   <= cnt_wr_c;
        count_out  <= cnt_next;
      end
    end
  end
endmodule

// File: rtl/br_eval_checker.sv
module br_eval_checker
  import br_eval_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FLAG_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [FLAG_W-1:0] flags,
  input logic [CNT_W-1:0]  count,
  input logic              out_valid,
  input logic              taken,
  input logic              not_branch,
  input logic              count_wr,
  input logic [CNT_W-1:0]  count_out,
  input logic              evt_jcc,
  input logic              evt_loop_plain,
  input logic              evt_loop_z,
  input logic              evt_loop_nz,
  input logic              evt_cx_test,
  input logic              evt_not_branch
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !taken && !not_branch && !count_wr && count_out == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_single_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones({evt_jcc, evt_loop_plain, evt_loop_z,
                             evt_loop_nz, evt_cx_test, evt_not_branch}) == 1);

  assert_loop_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && evt_loop_plain |=> count_wr && count_out == $past(count) - ONE
                                   && taken == (count_out != '0));

  assert_loopz_needs_zf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && evt_loop_z |=> count_wr && (!taken || $past(flags[FB_ZF])));

  assert_loopnz_needs_nzf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && evt_loop_nz |=> count_wr && (!taken || !$past(flags[FB_ZF])));

  assert_cx_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && evt_cx_test |=> !count_wr && count_out == $past(count)
                                && taken == ($past(count) == '0));

  assert_not_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && evt_not_branch |=> not_branch && !taken && !count_wr
                                   && count_out == $past(count));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !in_valid |=> $stable(taken) && $stable(count_out)
                                  && $stable(count_wr) && $stable(not_branch));
endmodule

bind branch_cond_eval br_eval_checker #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .flags          (flags),
  .count          (count),
  .out_valid      (out_valid),
  .taken          (taken),
  .not_branch     (not_branch),
  .count_wr       (count_wr),
  .count_out      (count_out),
  .evt_jcc        (evt_jcc),
  .evt_loop_plain (evt_loop_plain),
  .evt_loop_z     (evt_loop_z),
  .evt_loop_nz    (evt_loop_nz),
  .evt_cx_test    (evt_cx_test),
  .evt_not_branch (evt_not_branch)
);

// File: tb/branch_cond_eval_bench.sv
module branch_cond_eval_bench;
  localparam int CW = 16;
  localparam int FW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    opcode = '0;
  logic [FW-1:0] flags = '0;
  logic [CW-1:0] count = '0;
  logic          out_valid, taken, not_branch, count_wr;
  logic [CW-1:0] count_out;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic          tk;
    logic          nb;
    logic          wr;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;

  exp_t sb[$];
  exp_t last_exp;

  always #2 clk = ~clk;

  branch_cond_eval #(.CNT_W(CW), .FLAG_W(FW)) u_branch_cond_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .flags(flags), .count(count), .out_valid(out_valid), .taken(taken),
    .not_branch(not_branch), .count_wr(count_wr), .count_out(count_out)
  );

  // Independent reference: one case per mnemonic
  function automatic exp_t model(input logic [7:0] op, input logic [FW-1:0] f,
                                 input logic [CW-1:0] c, input string tag);
    exp_t e;
    logic cf, pf, zf, sf, ov;
    logic [CW-1:0] m;
    cf = f[0]; pf = f[2]; zf = f[6]; sf = f[7]; ov = f[11];
    m = c - 16'd1;
    e.tk = 1'b0; e.nb = 1'b0; e.wr = 1'b0; e.cnt = c; e.tag = tag;
    case (op)
      8'h70: e.tk = ov;
      8'h71: e.tk = !ov;
      8'h72: e.tk = cf;
      8'h73: e.tk = !cf;
      8'h74: e.tk = zf;
      8'h75: e.tk = !zf;
      8'h76: e.tk = cf || zf;
      8'h77: e.tk = !cf && !zf;
      8'h78: e.tk = sf;
      8'h79: e.tk = !sf;
      8'h7A: e.tk = pf;
      8'h7B: e.tk = !pf;
      8'h7C: e.tk = (sf != ov);
      8'h7D: e.tk = (sf == ov);
      8'h7E: e.tk = zf || (sf != ov);
      8'h7F: e.tk = !zf && (sf == ov);
      8'hE2: begin e.wr = 1'b1; e.cnt = m; e.tk = (m != 0); end
      8'hE1: begin e.wr = 1'b1; e.cnt = m; e.tk = (m != 0) && zf; end
      8'hE0: begin e.wr = 1'b1; e.cnt = m; e.tk = (m != 0) && !zf; end
      8'hE3: e.tk = (c == 0);
      default: e.nb = 1'b1;
    endcase
    return e;
  endfunction

  task automatic apply(input logic [7:0] op, input logic [FW-1:0] f,
                       input logic [CW-1:0] c, input string tag);
    @(negedge clk);
    opcode = op; flags = f; count = c; in_valid = 1'b1;
    sb.push_back(model(op, f, c, tag));
    last_exp = model(op, f, c, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Monitor: pops one expected item per valid result
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check("R2", "unexpected out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, "taken", {31'd0, taken}, {31'd0, e.tk});
          check(e.tag, "not_branch", {31'd0, not_branch}, {31'd0, e.nb});
          check(e.tag, "count_wr", {31'd0, count_wr}, {31'd0, e.wr});
          check(e.tag, "count_out", {16'd0, count_out}, {16'd0, e.cnt});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check("R2", "watchdog expired", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [FW-1:0] f;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1", "taken in reset", {31'd0, taken}, 32'd0);
    check("R1", "not_branch in reset", {31'd0, not_branch}, 32'd0);
    check("R1", "count_wr in reset", {31'd0, count_wr}, 32'd0);
    check("R1", "count_out in reset", {16'd0, count_out}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R3 / R4 / R5: all sixteen jumps against every combination of the five flags
    for (int op = 8'h70; op <= 8'h7F; op++) begin
      for (int p = 0; p < 32; p++) begin
        f = '0;
        f[0] = p[0]; f[2] = p[1]; f[6] = p[2]; f[7] = p[3]; f[11] = p[4];
        if (op == 8'h76 || op == 8'h7C || op == 8'h7E)
          apply(8'(op), f, 16'h1234, "R5");
        else if (op[0])
          apply(8'(op), f, 16'h1234, "R4");
        else
          apply(8'(op), f, 16'h1234, "R3");
      end
    end

    // R10: undefined and control flag bits toggled around the same defined flags
    for (int op = 8'h70; op <= 8'h7F; op++) begin
      apply(8'(op), 16'hF73A & ~16'h08C5, 16'h0007, "R10");
      apply(8'(op), 16'hFFFF & ~16'h08C5, 16'h0007, "R10");
      apply(8'(op), 16'hF73A | 16'h08C5, 16'h0007, "R10");
      apply(8'(op), 16'hFFFF, 16'h0007, "R10");
    end

    // R6 / R7 / R8: counts at the boundaries, ZF both ways
    for (int z = 0; z < 2; z++) begin
      f = z[0] ? 16'h0040 : 16'h0000;
      apply(8'hE2, f, 16'h0001, "R6");
      apply(8'hE2, f, 16'h0000, "R6");
      apply(8'hE2, f, 16'h0002, "R6");
      apply(8'hE2, f, 16'hFFFF, "R6");
      apply(8'hE1, f, 16'h0005, "R7");
      apply(8'hE1, f, 16'h0001, "R7");
      apply(8'hE1, f, 16'h0000, "R7");
      apply(8'hE0, f, 16'h0005, "R7");
      apply(8'hE0, f, 16'h0001, "R7");
      apply(8'hE0, f, 16'h8000, "R7");
      apply(8'hE3, f, 16'h0000, "R8");
      apply(8'hE3, f, 16'h0001, "R8");
      apply(8'hE3, f, 16'hFFFF, "R8");
    end

    // R9: every other opcode is reported as not a branch
    for (int op = 0; op < 256; op++) begin
      if (op[7:4] != 4'b0111 && op[7:2] != 6'b111000)
        apply(8'(op), 16'hFFFF, 16'(op * 16'h0101), "R9");
    end

    // R11: results hold while in_valid is low and inputs move
    apply(8'hE2, 16'h0000, 16'h0010, "R11");
    @(negedge clk);
    in_valid = 1'b0; opcode = 8'h90; count = 16'h0000; flags = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R11", "out_valid idle", {31'd0, out_valid}, 32'd0);
    check("R11", "taken held", {31'd0, taken}, {31'd0, last_exp.tk});
    check("R11", "count_wr held", {31'd0, count_wr}, {31'd0, last_exp.wr});
    check("R11", "count_out held", {16'd0, count_out}, {16'd0, last_exp.cnt});
    check("R11", "not_branch held", {31'd0, not_branch}, {31'd0, last_exp.nb});

    idle(3);
    check("R2", "results left unconsumed", sb.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule